// File: doc/BRIEF.md
# Two-Wide Static Packet Dispatcher

This block is the front end of a two-wide, in-order pipeline whose schedule is fixed ahead of time. Each cycle it presents a byte address on an aligned 64-bit instruction port and takes back one packet. The low word of the packet goes to the arithmetic/branch lane and the high word goes to the memory lane. The two lanes then move through decode, execute, memory and writeback registers together, one stage per cycle. The block never stalls and never looks for dependencies. A word placed in the wrong slot is flagged and replaced by a bubble.

The execute unit outside the block returns a branch decision for the arithmetic-lane instruction that is in execute. A taken branch moves fetch to an aligned target and removes the two packets fetched after it. The writeback values for both lanes also come from outside the block. A register file with four read ports and two write ports serves the decode stage. When both lanes write the same register in one cycle, the memory lane wins.

Top module: `dual_issue_dispatch`

## Requirements
- R1: While rst_ni is low, imem_addr_o equals RESET_PC with bits [2:0] cleared. All six stage instruction outputs and illegal_o are zero, and every register reads as zero.
- R2: imem_addr_o always has bits [2:0] at zero. It advances by 8 each cycle, wrapping modulo 2^ADDR_W, unless a redirect is taken. Fetch never stalls, whatever the dependencies between instructions.
- R3: Packet bits [31:0] travel down the arithmetic lane and bits [63:32] down the memory lane. A packet fetched in cycle t is in decode at t+1, execute at t+2, memory at t+3 and writeback at t+4, in both lanes together.
- R4: Bits [31:30] give the class: 00 nop, 01 arithmetic, 10 branch, 11 load/store, where bit 29 set means load. A class-11 word in the low slot, or a class-01 or class-10 word in the high slot, is replaced by 32'h0. illegal_o[lane] is then high for the one cycle in which that packet sits in decode (bit 0 for the low slot, bit 1 for the high slot).
- R5: When the execute-stage arithmetic instruction is of class 10 and br_taken_i is high, the next address is br_target_i with bits [2:0] cleared. The packets then in fetch and decode become all-zero bubbles, and their illegal flags are dropped.
- R6: br_taken_i has no effect when the execute-stage arithmetic instruction is not of class 10.
- R7: The four read ports return the registers named by decode-stage fields rs1 [20:16] and rs2 [15:11] of each lane. Register 0 always reads zero, and a read returns the value held before any write in the same cycle.
- R8: A writeback-stage class-01 instruction writes wb_alu_data_i to register rd [25:21]. A writeback-stage load writes wb_ls_data_i to rd. Stores, branches, nops and writes to register 0 change nothing.
- R9: When both lanes write the same register in one cycle, the memory-lane value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | ADDR_W | Fetch byte address |
| imem_data_i | input | 64 | Packet at imem_addr_o, same cycle |
| br_taken_i | input | 1 | Branch outcome for the execute-stage arithmetic instruction |
| br_target_i | input | ADDR_W | Branch target byte address |
| wb_alu_data_i | input | XLEN | Result for the writeback-stage arithmetic instruction |
| wb_ls_data_i | input | XLEN | Load data for the writeback-stage memory instruction |
| alu_rs1_data_o | output | XLEN | Arithmetic lane rs1 value |
| alu_rs2_data_o | output | XLEN | Arithmetic lane rs2 value |
| ls_rs1_data_o | output | XLEN | Memory lane rs1 value |
| ls_rs2_data_o | output | XLEN | Memory lane rs2 value |
| ex_alu_instr_o | output | 32 | Arithmetic lane, execute stage |
| ex_ls_instr_o | output | 32 | Memory lane, execute stage |
| mem_alu_instr_o | output | 32 | Arithmetic lane, memory stage |
| mem_ls_instr_o | output | 32 | Memory lane, memory stage |
| wb_alu_instr_o | output | 32 | Arithmetic lane, writeback stage |
| wb_ls_instr_o | output | 32 | Memory lane, writeback stage |
| illegal_o | output | 2 | Per-slot class violation, decode stage |

## Verification
The bench builds the block with ADDR_W = 9 and RESET_PC = 9'h1F0, which gives a 64-packet program space. Fetch therefore wraps to address zero two cycles after reset and keeps wrapping throughout the run, and random branch targets reach every packet. The 32-bit data width is kept, so register values stay wide enough that writes from the wrong lane cannot go unnoticed.

// File: rtl/dip_pkg.sv
package dip_pkg;
  localparam int INSTR_W = 32;
  localparam int PKT_W   = 2 * INSTR_W;
  localparam int REG_AW  = 5;
  localparam int NREG    = 1 << REG_AW;
  localparam int NRD     = 4;

  typedef enum logic [1:0] {
    CLS_NOP = 2'b00,
    CLS_ALU = 2'b01,
    CLS_BR  = 2'b10,
    CLS_LS  = 2'b11
  } cls_e;

  function automatic cls_e cls_of(input logic [INSTR_W-1:0] w);
    return cls_e'(w[31:30]);
  endfunction

  function automatic logic [REG_AW-1:0] rd_of(input logic [INSTR_W-1:0] w);
    return w[25:21];
  endfunction

  function automatic logic [REG_AW-1:0] rs1_of(input logic [INSTR_W-1:0] w);
    return w[20:16];
  endfunction

  function automatic logic [REG_AW-1:0] rs2_of(input logic [INSTR_W-1:0] w);
    return w[15:11];
  endfunction

  function automatic logic is_load(input logic [INSTR_W-1:0] w);
    return (cls_of(w) == CLS_LS) && w[29];
  endfunction
endpackage

// File: rtl/dip_fetch.sv
module dip_fetch #(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              redir_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] PC_INIT = {RESET_PC[ADDR_W-1:3], 3'b000};

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= PC_INIT;
    else if (redir_i) pc_q <= {tgt_i[ADDR_W-1:3], 3'b000};
    else              pc_q <= pc_q + STEP;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/dip_slot_check.sv
module dip_slot_check
  import dip_pkg::*;
#(
  parameter bit MEM_SLOT = 1'b0
) (
  input  logic [INSTR_W-1:0] word_i,
  output logic [INSTR_W-1:0] word_o,
  output logic               bad_o
);
  cls_e cls;
  assign cls = cls_of(word_i);

  generate
    if (MEM_SLOT) begin : g_mem
      assign bad_o = (cls == CLS_ALU) || (cls == CLS_BR);
    end else begin : g_alu
      assign bad_o = (cls == CLS_LS);
    end
  endgenerate

  assign word_o = bad_o ? '0 : word_i;
endmodule

// File: rtl/dip_lane_pipe.sv
module dip_lane_pipe
  import dip_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [INSTR_W-1:0] word_i,
  output logic [INSTR_W-1:0] id_o,
  output logic [INSTR_W-1:0] ex_o,
  output logic [INSTR_W-1:0] mem_o,
  output logic [INSTR_W-1:0] wb_o
);
  logic [INSTR_W-1:0] id_q, ex_q, mem_q, wb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q  <= '0;
      ex_q  <= '0;
      mem_q <= '0;
      wb_q  <= '0;
    end else begin
      // younger stages squashed on redirect
      id_q  <= flush_i ? '0 : word_i;
      ex_q  <= flush_i ? '0 : id_q;
      mem_q <= ex_q;
      wb_q  <= mem_q;
    end
  end

  assign id_o  = id_q;
  assign ex_o  = ex_q;
  assign mem_o = mem_q;
  assign wb_o  = wb_q;
endmodule

// File: rtl/dip_regfile.sv
module dip_regfile
  import dip_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NRD-1:0][REG_AW-1:0]  ra_i,
  output logic [NRD-1:0][XLEN-1:0]    rdata_o,
  input  logic [1:0]                  we_i,
  input  logic [1:0][REG_AW-1:0]      wa_i,
  input  logic [1:0][XLEN-1:0]        wd_i
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        // port 1 (memory lane) wins a collision
        if (we_i[1] && wa_i[1] == REG_AW'(i))      regs_q[i] <= wd_i[1];
        else if (we_i[0] && wa_i[0] == REG_AW'(i)) regs_q[i] <= wd_i[0];
      end
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rdata_o[k] = (ra_i[k] == '0) ? '0 : regs_q[ra_i[k]];
  end
endmodule

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch
  import dip_pkg::*;
#(
  parameter int                XLEN     = 32,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [ADDR_W-1:0]  imem_addr_o,
  input  logic [PKT_W-1:0]   imem_data_i,
  input  logic               br_taken_i,
  input  logic [ADDR_W-1:0]  br_target_i,
  input  logic [XLEN-1:0]    wb_alu_data_i,
  input  logic [XLEN-1:0]    wb_ls_data_i,
  output logic [XLEN-1:0]    alu_rs1_data_o,
  output logic [XLEN-1:0]    alu_rs2_data_o,
  output logic [XLEN-1:0]    ls_rs1_data_o,
  output logic [XLEN-1:0]    ls_rs2_data_o,
  output logic [INSTR_W-1:0] ex_alu_instr_o,
  output logic [INSTR_W-1:0] ex_ls_instr_o,
  output logic [INSTR_W-1:0] mem_alu_instr_o,
  output logic [INSTR_W-1:0] mem_ls_instr_o,
  output logic [INSTR_W-1:0] wb_alu_instr_o,
  output logic [INSTR_W-1:0] wb_ls_instr_o,
  output logic [1:0]         illegal_o
);
  localparam int NLANE = 2;

  logic [NLANE-1:0][INSTR_W-1:0] fetch_w, clean_w, id_w, ex_w, mem_w, wb_w;
  logic [NLANE-1:0]              bad_w;
  logic [1:0]                    ill_q;
  logic                          redir;

  assign redir = (cls_of(ex_w[0]) == CLS_BR) && br_taken_i;

  dip_fetch #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) i_fetch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .redir_i (redir),
    .tgt_i   (br_target_i),
    .pc_o    (imem_addr_o)
  );

  // low word -> lane 0 (alu/branch), high word -> lane 1 (load/store)
  assign fetch_w = imem_data_i;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    dip_slot_check #(.MEM_SLOT(g == 1)) i_chk (
      .word_i (fetch_w[g]),
      .word_o (clean_w[g]),
      .bad_o  (bad_w[g])
    );
    dip_lane_pipe i_pipe (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (redir),
      .word_i  (clean_w[g]),
      .id_o    (id_w[g]),
      .ex_o    (ex_w[g]),
      .mem_o   (mem_w[g]),
      .wb_o    (wb_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ill_q <= '0;
    else         ill_q <= redir ? 2'b00 : bad_w;
  end
  assign illegal_o = ill_q;

  logic [NRD-1:0][REG_AW-1:0] ra;
  logic [NRD-1:0][XLEN-1:0]   rdata;
  logic [1:0]                 we;
  logic [1:0][REG_AW-1:0]     wa;
  logic [1:0][XLEN-1:0]       wd;

  assign ra[0] = rs1_of(id_w[0]);
  assign ra[1] = rs2_of(id_w[0]);
  assign ra[2] = rs1_of(id_w[1]);
  assign ra[3] = rs2_of(id_w[1]);
  assign we[0] = (cls_of(wb_w[0]) == CLS_ALU);
  assign we[1] = is_load(wb_w[1]);
  assign wa[0] = rd_of(wb_w[0]);
  assign wa[1] = rd_of(wb_w[1]);
  assign wd[0] = wb_alu_data_i;
  assign wd[1] = wb_ls_data_i;

  dip_regfile #(.XLEN(XLEN)) i_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ra_i    (ra),
    .rdata_o (rdata),
    .we_i    (we),
    .wa_i    (wa),
    .wd_i    (wd)
  );

  assign alu_rs1_data_o  = rdata[0];
  assign alu_rs2_data_o  = rdata[1];
  assign ls_rs1_data_o   = rdata[2];
  assign ls_rs2_data_o   = rdata[3];
  assign ex_alu_instr_o  = ex_w[0];
  assign ex_ls_instr_o   = ex_w[1];
  assign mem_alu_instr_o = mem_w[0];
  assign mem_ls_instr_o  = mem_w[1];
  assign wb_alu_instr_o  = wb_w[0];
  assign wb_ls_instr_o   = wb_w[1];
endmodule

// File: rtl/dip_chk.sv
module dip_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] imem_addr_o,
  input logic              br_taken_i,
  input logic [ADDR_W-1:0] br_target_i,
  input logic [31:0]       ex_alu_instr_o,
  input logic [31:0]       ex_ls_instr_o,
  input logic [31:0]       mem_alu_instr_o,
  input logic [31:0]       mem_ls_instr_o,
  input logic [31:0]       wb_alu_instr_o,
  input logic [31:0]       wb_ls_instr_o,
  input logic [1:0]        illegal_o
);
  logic take;
  assign take = (ex_alu_instr_o[31:30] == 2'b10) && br_taken_i;

  // R2
  pc_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_addr_o[2:0] == 3'b000);

  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> imem_addr_o == $past(imem_addr_o) + ADDR_W'(8));

  // R5
  redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> imem_addr_o == {$past(br_target_i[ADDR_W-1:3]), 3'b000});

  // R5
  squash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (ex_alu_instr_o == '0) && (ex_ls_instr_o == '0) && (illegal_o == 2'b00));

  // R3
  lockstep_alu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mem_alu_instr_o == $past(ex_alu_instr_o)) &&
             (wb_alu_instr_o == $past(mem_alu_instr_o)));

  // R3
  lockstep_ls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mem_ls_instr_o == $past(ex_ls_instr_o)) &&
             (wb_ls_instr_o == $past(mem_ls_instr_o)));

  // R4
  slot_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_alu_instr_o[31:30] != 2'b11) &&
    (ex_ls_instr_o[31:30] == 2'b00 || ex_ls_instr_o[31:30] == 2'b11));

  // R4
  illegal_nop_alu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o[0] |=> ex_alu_instr_o == '0);

  // R4
  illegal_nop_ls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o[1] |=> ex_ls_instr_o == '0);
endmodule

bind dual_issue_dispatch dip_chk #(.ADDR_W(ADDR_W)) i_dip_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .imem_addr_o     (imem_addr_o),
  .br_taken_i      (br_taken_i),
  .br_target_i     (br_target_i),
  .ex_alu_instr_o  (ex_alu_instr_o),
  .ex_ls_instr_o   (ex_ls_instr_o),
  .mem_alu_instr_o (mem_alu_instr_o),
  .mem_ls_instr_o  (mem_ls_instr_o),
  .wb_alu_instr_o  (wb_alu_instr_o),
  .wb_ls_instr_o   (wb_ls_instr_o),
  .illegal_o       (illegal_o)
);

// File: tb/test_dual_issue_dispatch.sv
`timescale 1ns/1ps
module test_dual_issue_dispatch;
  localparam int AW = 9;
  localparam logic [AW-1:0] RST_PC = 9'h1F0;
  localparam int NPKT = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] imem_addr;
  logic [63:0]   imem_data;
  logic          br_taken = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic [31:0]   wb_alu_data = '0, wb_ls_data = '0;
  logic [31:0]   a1, a2, l1, l2;
  logic [31:0]   ex_a, ex_l, mem_a, mem_l, wb_a, wb_l;
  logic [1:0]    illegal;

  logic [63:0] prog [NPKT];

  always #2 clk = ~clk;

  always_comb imem_data = prog[imem_addr[8:3]];

  dual_issue_dispatch #(.XLEN(32), .ADDR_W(AW), .RESET_PC(RST_PC)) i_dual_issue_dispatch (
    .clk_i(clk), .rst_ni(rst_ni), .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .br_taken_i(br_taken), .br_target_i(br_target),
    .wb_alu_data_i(wb_alu_data), .wb_ls_data_i(wb_ls_data),
    .alu_rs1_data_o(a1), .alu_rs2_data_o(a2), .ls_rs1_data_o(l1), .ls_rs2_data_o(l2),
    .ex_alu_instr_o(ex_a), .ex_ls_instr_o(ex_l), .mem_alu_instr_o(mem_a),
    .mem_ls_instr_o(mem_l), .wb_alu_instr_o(wb_a), .wb_ls_instr_o(wb_l),
    .illegal_o(illegal)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [AW-1:0] epc;
  logic [31:0]   eid [2], eex [2], emem [2], ewb [2];
  logic [1:0]    eill;
  logic [31:0]   erf [32];
  int            coll_rd;
  bit            last_flush, last_ign;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen_word(input bit ls_slot);
    logic [31:0] w = $urandom;
    int r = int'($urandom % 16);
    if (!ls_slot) begin
      if (r < 2)       w[31:30] = 2'b00;
      else if (r < 9)  w[31:30] = 2'b01;
      else if (r < 14) w[31:30] = 2'b10;
      else if (r == 14) w[31:30] = 2'b11;  // misplaced
      else             w[31:30] = 2'b01;
    end else begin
      if (r < 3)       w[31:30] = 2'b00;
      else if (r < 13) w[31:30] = 2'b11;
      else if (r == 13) w[31:30] = 2'b01;  // misplaced
      else if (r == 14) w[31:30] = 2'b10;  // misplaced
      else             w[31:30] = 2'b11;
    end
    return w;
  endfunction

  function automatic logic [31:0] rf_exp(input logic [4:0] idx);
    return (idx == 5'd0) ? 32'h0 : erf[idx];
  endfunction

  function automatic string rd_tag(input logic [4:0] idx);
    if (idx == 5'd0) return "R7 r0 read";
    if (coll_rd >= 0 && int'(idx) == coll_rd) return "R9 collision read";
    return "R8 written value read";
  endfunction

  task automatic check_all();
    string ptag;
    string stag;
    ptag = last_flush ? "R5 redirect pc" : (last_ign ? "R6 ignored taken" : "R2 pc step");
    stag = last_flush ? "R5 squash ex" : "R3 ex";
    chk(ptag, 64'(imem_addr), 64'(epc));
    chk({stag, " alu"}, 64'(ex_a), 64'(eex[0]));
    chk({stag, " ls"}, 64'(ex_l), 64'(eex[1]));
    chk("R3 mem alu", 64'(mem_a), 64'(emem[0]));
    chk("R3 mem ls", 64'(mem_l), 64'(emem[1]));
    chk("R3 wb alu", 64'(wb_a), 64'(ewb[0]));
    chk("R3 wb ls", 64'(wb_l), 64'(ewb[1]));
    chk("R4 illegal flag", 64'(illegal), 64'(eill));
    chk(rd_tag(eid[0][20:16]), 64'(a1), 64'(rf_exp(eid[0][20:16])));
    chk(rd_tag(eid[0][15:11]), 64'(a2), 64'(rf_exp(eid[0][15:11])));
    chk(rd_tag(eid[1][20:16]), 64'(l1), 64'(rf_exp(eid[1][20:16])));
    chk(rd_tag(eid[1][15:11]), 64'(l2), 64'(rf_exp(eid[1][15:11])));
  endtask

  task automatic step_model();
    logic [63:0] pk;
    logic [31:0] w0, w1;
    logic b0, b1, flush, wr0;
    logic [4:0] rd0, rd1;
    pk = prog[epc[8:3]];
    w0 = pk[31:0];
    w1 = pk[63:32];
    b0 = (w0[31:30] == 2'b11);
    b1 = (w1[31:30] == 2'b01) || (w1[31:30] == 2'b10);
    flush = (eex[0][31:30] == 2'b10) && br_taken;
    last_flush = flush;
    last_ign = br_taken && !flush;
    // writeback
    rd0 = ewb[0][25:21];
    rd1 = ewb[1][25:21];
    wr0 = (ewb[0][31:30] == 2'b01) && rd0 != 5'd0;
    if (wr0) begin
      erf[rd0] = wb_alu_data;
      if (coll_rd == int'(rd0)) coll_rd = -1;
    end
    if (ewb[1][31:29] == 3'b111 && rd1 != 5'd0) begin
      erf[rd1] = wb_ls_data;
      if (wr0 && rd0 == rd1) coll_rd = int'(rd1);
      else if (coll_rd == int'(rd1)) coll_rd = -1;
    end
    for (int l = 0; l < 2; l++) begin
      ewb[l]  = emem[l];
      emem[l] = eex[l];
      eex[l]  = flush ? 32'h0 : eid[l];
    end
    eid[0] = flush ? 32'h0 : (b0 ? 32'h0 : w0);
    eid[1] = flush ? 32'h0 : (b1 ? 32'h0 : w1);
    eill   = flush ? 2'b00 : {b1, b0};
    epc    = flush ? {br_target[AW-1:3], 3'b000} : epc + AW'(8);
  endtask

  task automatic drive(input bit allow_br);
    wb_alu_data = $urandom;
    wb_ls_data  = $urandom;
    br_taken    = allow_br ? ($urandom % 4 == 0) : 1'b0;
    br_target   = AW'($urandom);
  endtask

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20250917));
    for (int p = 0; p < NPKT; p++) prog[p] = {gen_word(1'b1), gen_word(1'b0)};
    // directed collision: both lanes write r7
    w = $urandom; w[31:29] = 3'b111; w[25:21] = 5'd7; prog[5][63:32] = w;
    w = $urandom; w[31:30] = 2'b01;  w[25:21] = 5'd7; prog[5][31:0]  = w;
    prog[6] = 64'h0; prog[7] = 64'h0; prog[8] = 64'h0;
    for (int p = 9; p < 11; p++) begin
      w = $urandom; w[31:30] = 2'b01; w[20:16] = 5'd7; w[15:11] = 5'd7; prog[p][31:0] = w;
      w = $urandom; w[31:29] = 3'b110; w[20:16] = 5'd7; w[15:11] = 5'd0; prog[p][63:32] = w;
    end
    // directed misplaced words in both slots
    prog[12] = {32'h4000_1234, 32'hC000_5678};

    epc = {RST_PC[AW-1:3], 3'b000};
    for (int l = 0; l < 2; l++) begin
      eid[l] = '0; eex[l] = '0; emem[l] = '0; ewb[l] = '0;
    end
    eill = '0;
    for (int r = 0; r < 32; r++) erf[r] = '0;
    coll_rd = -1;
    last_flush = 1'b0;
    last_ign = 1'b0;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset pc", 64'(imem_addr), 64'(epc));
    chk("R1 reset stages", {ex_a, ex_l} | {mem_a, mem_l} | {wb_a, wb_l}, 64'h0);
    chk("R1 reset illegal", 64'(illegal), 64'h0);
    chk("R1 reset reads", {a1 | a2, l1 | l2}, 64'h0);
    rst_ni = 1'b1;

    // directed phase: no branches, wrap and collision
    for (int c = 0; c < 80; c++) begin
      drive(1'b0);
      step_model();
      @(negedge clk);
      check_all();
    end
    // random phase with branches
    for (int c = 0; c < 1200; c++) begin
      drive(1'b1);
      step_model();
      @(negedge clk);
      check_all();
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule